// File: doc/BRIEF.md
# Dual-Lane Pre-Add Multiply ALU Slice

This block is an arithmetic slice with two multiply lanes and a shared combining stage. Each lane registers three operands, A, D and B. It then forms a pre-sum A±D and multiplies that pre-sum by B. The pre-sum has no path of its own: it only ever feeds its own lane's multiplier. A combining stage of configurable width takes the two lane products and a third operand C. It either adds them with independently chosen signs or forms a bitwise logic function of the second product and C. One 72-bit output register holds the result. In plain multiply mode it carries both 36-bit products side by side. In the other two modes it carries the sign-extended combining result.

The A and B operand registers of the two lanes also form a shift chain. A slice can take samples from a neighbour on the cascade inputs, move them from lane 0 to lane 1, and hand lane 1's values to the next slice on the cascade outputs. When the `CASC_MATCH` parameter is set, an extra register sits on the A cascade output to balance a chain. The operand width (9 or 18 bits) and the combining width (24 or 54 bits) are elaboration parameters. Every sample passes through three register stages, and a valid flag travels with it.

Top module: `premul_alu_slice`

## Requirements
- R1: Each lane n forms pre = An + Dn when pre_sub[n] = 0 and An − Dn when pre_sub[n] = 1. The pre-sum wraps at the operand width. The lane product is pre × Bn, signed, sign-extended to 36 bits.
- R2: With OPW = 9, only bits [8:0] of each 18-bit operand input are used, read as signed. The pre-sum wraps at 9 bits.
- R3: With alu_mode 00 or 11, res_out[71:36] holds the lane 1 product and res_out[35:0] holds the lane 0 product.
- R4: With alu_mode 01, the result is P0 + (neg_b ? −P1 : P1) + (neg_c ? −C : C), computed modulo 2^ALU_W. It is sign-extended from bit ALU_W−1 to 72 bits.
- R5: With alu_mode 10, the result is a bitwise function of P1 and C at ALU_W bits, sign-extended from bit ALU_W−1. The function is set by logic_op: 00 gives AND, 01 gives OR, 10 gives XOR and 11 gives XNOR.
- R6: Operands, C, the controls and in_vld are sampled at clock edge k. The matching res_out and res_vld appear after edge k+2.
- R7: With shift_a = 1, lane 0's A register loads casc_a_in, lane 1's A register loads lane 0's previous A, and a0_in and a1_in are ignored. shift_b does the same for B with casc_b_in, b0_in and b1_in. casc_b_out is lane 1's B register.
- R8: casc_a_out is lane 1's A register delayed by one more register when CASC_MATCH = 1, and lane 1's A register directly when CASC_MATCH = 0.
- R9: A synchronous rst clears every register. res_out, res_vld, casc_a_out and casc_b_out read zero after any edge with rst high.
- R10: Before combining, each product is sign-extended to ALU_W when ALU_W exceeds 36 bits. When ALU_W is 36 bits or less, each product is cut to its low ALU_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Marks the sample presented this cycle |
| a0_in | input | 18 | Lane 0 pre-adder first operand |
| d0_in | input | 18 | Lane 0 pre-adder second operand |
| b0_in | input | 18 | Lane 0 multiplier operand |
| a1_in | input | 18 | Lane 1 pre-adder first operand |
| d1_in | input | 18 | Lane 1 pre-adder second operand |
| b1_in | input | 18 | Lane 1 multiplier operand |
| c_in | input | ALU_W | Third combining operand |
| shift_a | input | 1 | A registers load from the cascade chain |
| shift_b | input | 1 | B registers load from the cascade chain |
| casc_a_in | input | 18 | A sample from the previous slice |
| casc_b_in | input | 18 | B sample from the previous slice |
| pre_sub | input | 2 | Per-lane pre-adder subtract select |
| alu_mode | input | 2 | 00/11 products, 01 arithmetic, 10 logic |
| neg_b | input | 1 | Subtract P1 in arithmetic mode |
| neg_c | input | 1 | Subtract C in arithmetic mode |
| logic_op | input | 2 | Logic function select |
| res_out | output | 72 | Shared output register |
| res_vld | output | 1 | Valid flag aligned with res_out |
| casc_a_out | output | 18 | A sample to the next slice |
| casc_b_out | output | 18 | B sample to the next slice |

## Verification
The in-RTL properties run on every cycle. They cover the valid flag's stage-by-stage alignment, the packing of the lane 1 product in multiply mode, sign extension of every combining result, and the clearing effect of reset. They also cover one-step motion along the shift chain, the delay of the cascade match register, and the zero product that follows a zero multiplier operand. Only the bench's scenarios can show the arithmetic values themselves. These include pre-sum wrap at both operand widths, every sign and logic-function combination, and product truncation in a narrow combining stage. The bench also shows that the port operands are ignored while shifting and that a reset in the middle of a stream flushes every sample in flight. It runs three configurations side by side against a behavioural model.

// File: rtl/mac_slice_pkg.sv
package mac_slice_pkg;
   localparam int REG_W  = 18;
   localparam int PROD_W = 2 * REG_W;
   localparam int OUT_W  = 2 * PROD_W;
   localparam int LANES  = 2;

   typedef enum logic [1:0] {
      MODE_MULT  = 2'b00,
      MODE_ARITH = 2'b01,
      MODE_LOGIC = 2'b10,
      MODE_RSVD  = 2'b11
   } alu_mode_e;

   typedef enum logic [1:0] {
      LOP_AND  = 2'b00,
      LOP_OR   = 2'b01,
      LOP_XOR  = 2'b10,
      LOP_XNOR = 2'b11
   } logic_op_e;

   typedef struct packed {
      alu_mode_e        mode;
      logic             neg_b;
      logic             neg_c;
      logic_op_e        lop;
      logic [LANES-1:0] pre_sub;
   } slice_ctl_t;
endpackage

// File: rtl/slice_in_regs.sv
module slice_in_regs
   import mac_slice_pkg::*;
#(
   parameter bit CASC_MATCH = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [LANES-1:0][REG_W-1:0] a_in,
   input  logic [LANES-1:0][REG_W-1:0] d_in,
   input  logic [LANES-1:0][REG_W-1:0] b_in,
   input  logic                        shift_a,
   input  logic                        shift_b,
   input  logic [REG_W-1:0]            casc_a_in,
   input  logic [REG_W-1:0]            casc_b_in,
   output logic [LANES-1:0][REG_W-1:0] a_q,
   output logic [LANES-1:0][REG_W-1:0] d_q,
   output logic [LANES-1:0][REG_W-1:0] b_q,
   output logic [REG_W-1:0]            casc_a_out,
   output logic [REG_W-1:0]            casc_b_out
);
   // chain source: lane 0 takes the cascade input, lane n takes lane n-1
   logic [LANES-1:0][REG_W-1:0] a_src, b_src;
   assign a_src = {a_q[LANES-2:0], casc_a_in};
   assign b_src = {b_q[LANES-2:0], casc_b_in};

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q <= '0;
         d_q <= '0;
         b_q <= '0;
      end else begin
         a_q <= shift_a ? a_src : a_in;
         b_q <= shift_b ? b_src : b_in;
         d_q <= d_in;
      end
   end

   assign casc_b_out = b_q[LANES-1];

   generate
      if (CASC_MATCH) begin : g_match
         logic [REG_W-1:0] match_q;
         always_ff @(posedge clk) begin
            if (rst) match_q <= '0;
            else     match_q <= a_q[LANES-1];
         end
         assign casc_a_out = match_q;

         // R8
         casc_match_chk: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (casc_a_out == $past(a_q[LANES-1])));
      end else begin : g_direct
         assign casc_a_out = a_q[LANES-1];
      end
   endgenerate

   // R7
   shift_chain_chk: assert property (@(posedge clk) disable iff (rst)
      shift_a |=> (a_q[1] == $past(a_q[0])));

   // R7
   shift_head_chk: assert property (@(posedge clk) disable iff (rst)
      shift_b |=> (b_q[0] == $past(casc_b_in)));
endmodule

// File: rtl/slice_lane.sv
module slice_lane
   import mac_slice_pkg::*;
#(
   parameter int OPW = 18
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [REG_W-1:0]  a,
   input  logic [REG_W-1:0]  d,
   input  logic [REG_W-1:0]  b,
   input  logic              sub,
   output logic [PROD_W-1:0] prod_q
);
   localparam int PW = 2 * OPW;

   logic signed [OPW-1:0] a_s, d_s, b_s, pre_s;
   logic signed [PW-1:0]  mul_s;
   logic [PROD_W-1:0]     prod_d;

   assign a_s = a[OPW-1:0];
   assign d_s = d[OPW-1:0];
   assign b_s = b[OPW-1:0];

   // pre-sum wraps at the operand width and only feeds this multiplier
   always_comb pre_s = sub ? (a_s - d_s) : (a_s + d_s);
   assign mul_s = PW'(pre_s) * PW'(b_s);

   generate
      if (PW < PROD_W) begin : g_narrow
         logic unused_hi;
         assign unused_hi = ^{a[REG_W-1:OPW], d[REG_W-1:OPW], b[REG_W-1:OPW]};
         assign prod_d = {{(PROD_W-PW){mul_s[PW-1]}}, mul_s};

         // R2
         narrow_fit_chk: assert property (@(posedge clk) disable iff (rst)
            ($countones(prod_q[PROD_W-1:PW-1]) == 0) ||
            ($countones(prod_q[PROD_W-1:PW-1]) == PROD_W-PW+1));
      end else begin : g_full
         assign prod_d = mul_s;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) prod_q <= '0;
      else     prod_q <= prod_d;
   end

   // R1
   zero_mult_chk: assert property (@(posedge clk) disable iff (rst)
      (b[OPW-1:0] == '0) |=> (prod_q == '0));
endmodule

// File: rtl/slice_alu.sv
module slice_alu
   import mac_slice_pkg::*;
#(
   parameter int ALU_W = 54
) (
   input  logic [PROD_W-1:0] p0,
   input  logic [PROD_W-1:0] p1,
   input  logic [ALU_W-1:0]  c,
   input  slice_ctl_t        ctl,
   output logic [OUT_W-1:0]  res
);
   logic [ALU_W-1:0] p0w, p1w, term_b, term_c, sum, lres, r;

   generate
      if (ALU_W > PROD_W) begin : g_ext
         assign p0w = {{(ALU_W-PROD_W){p0[PROD_W-1]}}, p0};
         assign p1w = {{(ALU_W-PROD_W){p1[PROD_W-1]}}, p1};
      end else if (ALU_W == PROD_W) begin : g_same
         assign p0w = p0;
         assign p1w = p1;
      end else begin : g_trunc
         assign p0w = p0[ALU_W-1:0];
         assign p1w = p1[ALU_W-1:0];
      end
   endgenerate

   always_comb begin
      term_b = ctl.neg_b ? ('0 - p1w) : p1w;
      term_c = ctl.neg_c ? ('0 - c)   : c;
      sum    = p0w + term_b + term_c;
      case (ctl.lop)
         LOP_AND: lres = p1w & c;
         LOP_OR:  lres = p1w | c;
         LOP_XOR: lres = p1w ^ c;
         default: lres = ~(p1w ^ c);
      endcase
      case (ctl.mode)
         MODE_ARITH: r = sum;
         MODE_LOGIC: r = lres;
         default:    r = '0;
      endcase
      if (ctl.mode == MODE_ARITH || ctl.mode == MODE_LOGIC)
         res = {{(OUT_W-ALU_W){r[ALU_W-1]}}, r};
      else
         res = {p1, p0};
   end
endmodule

// File: rtl/premul_alu_slice.sv
module premul_alu_slice
   import mac_slice_pkg::*;
#(
   parameter int OPW        = 18,
   parameter int ALU_W      = 54,
   parameter bit CASC_MATCH = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_vld,
   input  logic [17:0]      a0_in,
   input  logic [17:0]      d0_in,
   input  logic [17:0]      b0_in,
   input  logic [17:0]      a1_in,
   input  logic [17:0]      d1_in,
   input  logic [17:0]      b1_in,
   input  logic [ALU_W-1:0] c_in,
   input  logic             shift_a,
   input  logic             shift_b,
   input  logic [17:0]      casc_a_in,
   input  logic [17:0]      casc_b_in,
   input  logic [1:0]       pre_sub,
   input  logic [1:0]       alu_mode,
   input  logic             neg_b,
   input  logic             neg_c,
   input  logic [1:0]       logic_op,
   output logic [71:0]      res_out,
   output logic             res_vld,
   output logic [17:0]      casc_a_out,
   output logic [17:0]      casc_b_out
);
   generate
      if (!(OPW == 9 || OPW == REG_W)) begin : g_bad_opw
         $error("premul_alu_slice: OPW must be 9 or 18");
      end
      if (!(ALU_W == 24 || ALU_W == 54)) begin : g_bad_aluw
         $error("premul_alu_slice: ALU_W must be 24 or 54");
      end
   endgenerate

   logic [LANES-1:0][REG_W-1:0] a_pk, d_pk, b_pk, a_q, d_q, b_q;
   assign a_pk = {a1_in, a0_in};
   assign d_pk = {d1_in, d0_in};
   assign b_pk = {b1_in, b0_in};

   slice_in_regs #(.CASC_MATCH(CASC_MATCH)) u_in (
      .clk        (clk),
      .rst        (rst),
      .a_in       (a_pk),
      .d_in       (d_pk),
      .b_in       (b_pk),
      .shift_a    (shift_a),
      .shift_b    (shift_b),
      .casc_a_in  (casc_a_in),
      .casc_b_in  (casc_b_in),
      .a_q        (a_q),
      .d_q        (d_q),
      .b_q        (b_q),
      .casc_a_out (casc_a_out),
      .casc_b_out (casc_b_out)
   );

   slice_ctl_t       ctl_in, ctl1, ctl2;
   logic [ALU_W-1:0] c1, c2;
   logic             vld1, vld2;

   assign ctl_in.mode    = alu_mode_e'(alu_mode);
   assign ctl_in.neg_b   = neg_b;
   assign ctl_in.neg_c   = neg_c;
   assign ctl_in.lop     = logic_op_e'(logic_op);
   assign ctl_in.pre_sub = pre_sub;

   // stage 1 and stage 2 carriers for C, controls and valid
   always_ff @(posedge clk) begin
      if (rst) begin
         ctl1 <= '0;
         ctl2 <= '0;
         c1   <= '0;
         c2   <= '0;
         vld1 <= 1'b0;
         vld2 <= 1'b0;
      end else begin
         ctl1 <= ctl_in;
         ctl2 <= ctl1;
         c1   <= c_in;
         c2   <= c1;
         vld1 <= in_vld;
         vld2 <= vld1;
      end
   end

   logic [LANES-1:0][PROD_W-1:0] prod;

   generate
      for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
         slice_lane #(.OPW(OPW)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .a      (a_q[ln]),
            .d      (d_q[ln]),
            .b      (b_q[ln]),
            .sub    (ctl1.pre_sub[ln]),
            .prod_q (prod[ln])
         );
      end
   endgenerate

   logic [OUT_W-1:0] alu_res;

   slice_alu #(.ALU_W(ALU_W)) u_alu (
      .p0  (prod[0]),
      .p1  (prod[1]),
      .c   (c2),
      .ctl (ctl2),
      .res (alu_res)
   );

   // shared output register
   always_ff @(posedge clk) begin
      if (rst) begin
         res_out <= '0;
         res_vld <= 1'b0;
      end else begin
         res_out <= alu_res;
         res_vld <= vld2;
      end
   end

   // R6
   valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (res_vld == $past(vld2)));

   // R3
   mult_pack_chk: assert property (@(posedge clk) disable iff (rst)
      (ctl2.mode == MODE_MULT) |=> (res_out[OUT_W-1:PROD_W] == $past(prod[1])));

   // R4 R5
   alu_sext_chk: assert property (@(posedge clk) disable iff (rst)
      (ctl2.mode == MODE_ARITH || ctl2.mode == MODE_LOGIC) |=>
      ((&res_out[OUT_W-1:ALU_W-1]) || (res_out[OUT_W-1:ALU_W-1] == '0)));

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (res_out == '0 && !res_vld && casc_b_out == '0));
endmodule

// File: tb/premul_alu_slice_tb.sv
module slice_ref_model #(
   parameter int    OPW        = 18,
   parameter int    ALU_W      = 54,
   parameter bit    CASC_MATCH = 1'b1,
   parameter string NAME       = "cfg"
) (
   input logic        clk,
   input logic        rst,
   input logic        in_vld,
   input logic [17:0] a0_in,
   input logic [17:0] d0_in,
   input logic [17:0] b0_in,
   input logic [17:0] a1_in,
   input logic [17:0] d1_in,
   input logic [17:0] b1_in,
   input logic [53:0] c_in,
   input logic        shift_a,
   input logic        shift_b,
   input logic [17:0] casc_a_in,
   input logic [17:0] casc_b_in,
   input logic [1:0]  pre_sub,
   input logic [1:0]  alu_mode,
   input logic        neg_b,
   input logic        neg_c,
   input logic [1:0]  logic_op,
   input logic [71:0] res_out,
   input logic        res_vld,
   input logic [17:0] casc_a_out,
   input logic [17:0] casc_b_out
);
   typedef struct {
      logic [71:0] r;
      bit          v;
      string       tag;
   } exp_t;

   exp_t        q[$];
   exp_t        cur;
   logic [17:0] ma0, ma1, md0, md1, mb0, mb1, msa;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          live  = 0;

   function automatic longint sx(longint v, int w);
      return (v <<< (64 - w)) >>> (64 - w);
   endfunction

   function automatic longint lane_prod(logic [17:0] a, logic [17:0] d, logic [17:0] b, bit sub);
      longint ao, dv, bo, pre;
      ao  = sx(longint'(a), OPW);
      dv  = sx(longint'(d), OPW);
      bo  = sx(longint'(b), OPW);
      pre = sub ? (ao - dv) : (ao + dv);
      pre = sx(pre, OPW);
      return pre * bo;
   endfunction

   function automatic exp_t predict();
      exp_t              e;
      longint            p0, p1, w0, w1, cc, r;
      logic [63:0]       t0, t1;
      logic signed [71:0] wide;
      string             sfx;
      sfx = "";
      if (OPW < 18)  sfx = {sfx, " R2"};
      if (ALU_W < 36) sfx = {sfx, " R10"};
      p0 = lane_prod(ma0, md0, mb0, pre_sub[0]);
      p1 = lane_prod(ma1, md1, mb1, pre_sub[1]);
      w0 = sx(p0, ALU_W);
      w1 = sx(p1, ALU_W);
      cc = sx(longint'(c_in), ALU_W);
      e.v = in_vld;
      if (alu_mode == 2'b01) begin
         r    = w0 + (neg_b ? -w1 : w1) + (neg_c ? -cc : cc);
         r    = sx(r, ALU_W);
         wide = r;
         e.r  = wide;
         e.tag = {"R1 R4", sfx};
      end else if (alu_mode == 2'b10) begin
         case (logic_op)
            2'b00:   r = w1 & cc;
            2'b01:   r = w1 | cc;
            2'b10:   r = w1 ^ cc;
            default: r = ~(w1 ^ cc);
         endcase
         r    = sx(r, ALU_W);
         wide = r;
         e.r  = wide;
         e.tag = {"R1 R5", sfx};
      end else begin
         t0  = p0;
         t1  = p1;
         e.r = {t1[35:0], t0[35:0]};
         e.tag = {"R1 R3", sfx};
      end
      return e;
   endfunction

   task automatic chk(bit ok, string tag, logic [71:0] act, logic [71:0] expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", NAME, tag, act, expv);
      end
   endtask

   always @(posedge clk) begin
      exp_t z;
      z.r = '0;
      z.v = 1'b0;
      z.tag = "R9";
      if (rst) begin
         ma0 = '0; ma1 = '0; md0 = '0; md1 = '0; mb0 = '0; mb1 = '0; msa = '0;
         q.delete();
         q.push_back(z);
         q.push_back(z);
         cur  = z;
         live = 1;
      end else if (live) begin
         msa = ma1;
         if (shift_a) begin ma1 = ma0; ma0 = casc_a_in; end
         else         begin ma0 = a0_in; ma1 = a1_in; end
         if (shift_b) begin mb1 = mb0; mb0 = casc_b_in; end
         else         begin mb0 = b0_in; mb1 = b1_in; end
         md0 = d0_in;
         md1 = d1_in;
         q.push_back(predict());
         cur = q.pop_front();
      end
   end

   always @(negedge clk) begin
      if (live) begin
         chk(res_out === cur.r, cur.tag, res_out, cur.r);
         chk(res_vld === cur.v, "R6 valid", 72'(res_vld), 72'(cur.v));
         chk(casc_a_out === (CASC_MATCH ? msa : ma1), "R8 casc_a_out",
             72'(casc_a_out), 72'(CASC_MATCH ? msa : ma1));
         chk(casc_b_out === mb1, "R7 casc_b_out", 72'(casc_b_out), 72'(mb1));
      end
   end
endmodule

module premul_alu_slice_tb_top;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst, in_vld, shift_a, shift_b, neg_b, neg_c;
   logic [17:0] a0, d0, b0, a1, d1, b1, ca, cb;
   logic [53:0] c;
   logic [1:0]  pre_sub, alu_mode, logic_op;

   logic [71:0] res_w, res_n, res_t;
   logic        vld_w, vld_n, vld_t;
   logic [17:0] sa_w, sb_w, sa_n, sb_n, sa_t, sb_t;

   int top_chk = 0;
   int top_bad = 0;
   bit done    = 0;

   premul_alu_slice dut_i (
      .clk(clk), .rst(rst), .in_vld(in_vld),
      .a0_in(a0), .d0_in(d0), .b0_in(b0), .a1_in(a1), .d1_in(d1), .b1_in(b1),
      .c_in(c), .shift_a(shift_a), .shift_b(shift_b),
      .casc_a_in(ca), .casc_b_in(cb), .pre_sub(pre_sub), .alu_mode(alu_mode),
      .neg_b(neg_b), .neg_c(neg_c), .logic_op(logic_op),
      .res_out(res_w), .res_vld(vld_w), .casc_a_out(sa_w), .casc_b_out(sb_w)
   );

   premul_alu_slice #(.OPW(9), .ALU_W(24), .CASC_MATCH(1'b0)) dut_n (
      .clk(clk), .rst(rst), .in_vld(in_vld),
      .a0_in(a0), .d0_in(d0), .b0_in(b0), .a1_in(a1), .d1_in(d1), .b1_in(b1),
      .c_in(c[23:0]), .shift_a(shift_a), .shift_b(shift_b),
      .casc_a_in(ca), .casc_b_in(cb), .pre_sub(pre_sub), .alu_mode(alu_mode),
      .neg_b(neg_b), .neg_c(neg_c), .logic_op(logic_op),
      .res_out(res_n), .res_vld(vld_n), .casc_a_out(sa_n), .casc_b_out(sb_n)
   );

   premul_alu_slice #(.OPW(18), .ALU_W(24), .CASC_MATCH(1'b1)) dut_t (
      .clk(clk), .rst(rst), .in_vld(in_vld),
      .a0_in(a0), .d0_in(d0), .b0_in(b0), .a1_in(a1), .d1_in(d1), .b1_in(b1),
      .c_in(c[23:0]), .shift_a(shift_a), .shift_b(shift_b),
      .casc_a_in(ca), .casc_b_in(cb), .pre_sub(pre_sub), .alu_mode(alu_mode),
      .neg_b(neg_b), .neg_c(neg_c), .logic_op(logic_op),
      .res_out(res_t), .res_vld(vld_t), .casc_a_out(sa_t), .casc_b_out(sb_t)
   );

   slice_ref_model #(.OPW(18), .ALU_W(54), .CASC_MATCH(1'b1), .NAME("w18x54")) m_w (
      .clk(clk), .rst(rst), .in_vld(in_vld),
      .a0_in(a0), .d0_in(d0), .b0_in(b0), .a1_in(a1), .d1_in(d1), .b1_in(b1),
      .c_in(c), .shift_a(shift_a), .shift_b(shift_b),
      .casc_a_in(ca), .casc_b_in(cb), .pre_sub(pre_sub), .alu_mode(alu_mode),
      .neg_b(neg_b), .neg_c(neg_c), .logic_op(logic_op),
      .res_out(res_w), .res_vld(vld_w), .casc_a_out(sa_w), .casc_b_out(sb_w)
   );

   slice_ref_model #(.OPW(9), .ALU_W(24), .CASC_MATCH(1'b0), .NAME("n9x24")) m_n (
      .clk(clk), .rst(rst), .in_vld(in_vld),
      .a0_in(a0), .d0_in(d0), .b0_in(b0), .a1_in(a1), .d1_in(d1), .b1_in(b1),
      .c_in(c), .shift_a(shift_a), .shift_b(shift_b),
      .casc_a_in(ca), .casc_b_in(cb), .pre_sub(pre_sub), .alu_mode(alu_mode),
      .neg_b(neg_b), .neg_c(neg_c), .logic_op(logic_op),
      .res_out(res_n), .res_vld(vld_n), .casc_a_out(sa_n), .casc_b_out(sb_n)
   );

   slice_ref_model #(.OPW(18), .ALU_W(24), .CASC_MATCH(1'b1), .NAME("t18x24")) m_t (
      .clk(clk), .rst(rst), .in_vld(in_vld),
      .a0_in(a0), .d0_in(d0), .b0_in(b0), .a1_in(a1), .d1_in(d1), .b1_in(b1),
      .c_in(c), .shift_a(shift_a), .shift_b(shift_b),
      .casc_a_in(ca), .casc_b_in(cb), .pre_sub(pre_sub), .alu_mode(alu_mode),
      .neg_b(neg_b), .neg_c(neg_c), .logic_op(logic_op),
      .res_out(res_t), .res_vld(vld_t), .casc_a_out(sa_t), .casc_b_out(sb_t)
   );

   task automatic report();
      int total, bad;
      total = top_chk + m_w.n_chk + m_n.n_chk + m_t.n_chk;
      bad   = top_bad + m_w.n_bad + m_n.n_bad + m_t.n_bad;
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   task automatic put(input logic [1:0] m, input logic [1:0] ps, input bit nb, input bit nc,
                      input logic [1:0] lo,
                      input logic [17:0] xa0, input logic [17:0] xd0, input logic [17:0] xb0,
                      input logic [17:0] xa1, input logic [17:0] xd1, input logic [17:0] xb1,
                      input logic [53:0] xc);
      @(negedge clk);
      in_vld = 1'b1; shift_a = 1'b0; shift_b = 1'b0;
      alu_mode = m; pre_sub = ps; neg_b = nb; neg_c = nc; logic_op = lo;
      a0 = xa0; d0 = xd0; b0 = xb0; a1 = xa1; d1 = xd1; b1 = xb1; c = xc;
   endtask

   task automatic rand_in();
      a0 = 18'($urandom); d0 = 18'($urandom); b0 = 18'($urandom);
      a1 = 18'($urandom); d1 = 18'($urandom); b1 = 18'($urandom);
      c  = {22'($urandom), 32'($urandom)};
      ca = 18'($urandom); cb = 18'($urandom);
      pre_sub = 2'($urandom); alu_mode = 2'($urandom);
      logic_op = 2'($urandom); neg_b = 1'($urandom); neg_c = 1'($urandom);
      in_vld = 1'($urandom);
   endtask

   initial begin
      rst = 1'b1; in_vld = 1'b0; shift_a = 1'b0; shift_b = 1'b0;
      a0 = '0; d0 = '0; b0 = '0; a1 = '0; d1 = '0; b1 = '0; c = '0;
      ca = '0; cb = '0; pre_sub = '0; alu_mode = '0; logic_op = '0;
      neg_b = 1'b0; neg_c = 1'b0;
      repeat (4) @(negedge clk);
      // R9: outputs held at zero during reset
      top_chk++;
      if (res_w !== '0 || vld_w !== 1'b0 || sa_w !== '0 || sb_w !== '0) begin
         top_bad++;
         $display("FAIL R9 reset state: actual=%h/%b expected=0/0", res_w, vld_w);
      end
      rst = 1'b0;

      // R1 R3: pre-sum wrap at both extremes, products packed side by side
      put(2'b00, 2'b00, 0, 0, 2'b00, 18'h1FFFF, 18'h00001, 18'h00002,
          18'h20000, 18'h00001, 18'h3FFFF, 54'd0);
      put(2'b00, 2'b10, 0, 0, 2'b00, 18'h1FFFF, 18'h00001, 18'h00002,
          18'h20000, 18'h00001, 18'h3FFFF, 54'd0);
      put(2'b11, 2'b01, 0, 0, 2'b00, 18'h000FF, 18'h00001, 18'h00003,
          18'h00100, 18'h00001, 18'h000FF, 54'd0);
      put(2'b00, 2'b11, 0, 0, 2'b00, 18'h20000, 18'h20000, 18'h20000,
          18'h1FFFF, 18'h1FFFF, 18'h1FFFF, 54'd0);
      // R4 R10: every sign combination with C at its extremes
      for (int k = 0; k < 4; k++) begin
         put(2'b01, 2'b00, k[0], k[1], 2'b00, 18'h1FFFF, 18'h00000, 18'h1FFFF,
             18'h20000, 18'h00000, 18'h1FFFF, 54'h20_0000_0000_0000);
         put(2'b01, 2'b01, k[0], k[1], 2'b00, 18'h00123, 18'h00045, 18'h3FF00,
             18'h00077, 18'h3FFFF, 18'h00099, 54'h1F_FFFF_FFFF_FFFF);
      end
      // R5: each logic function
      for (int k = 0; k < 4; k++) begin
         put(2'b10, 2'b00, 0, 0, 2'(k), 18'h12345, 18'h00111, 18'h2ABCD,
             18'h3C3C3, 18'h01010, 18'h15A5A, 54'h15_5555_AAAA_F0F0);
      end
      // R7 R8: shift both chains, port operands driven with noise
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         rand_in();
         in_vld = 1'b1; shift_a = 1'b1; shift_b = (k % 2) == 0;
         ca = 18'(18'h00101 * (k + 1)); cb = 18'(18'h02002 * (k + 1));
      end
      // R6: sparse valid pattern
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         rand_in();
         shift_a = 1'b0; shift_b = 1'b0; in_vld = (k % 3) == 0;
      end
      // R9: reset in the middle of a stream
      @(negedge clk);
      rand_in();
      in_vld = 1'b1;
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      // random mix of every mode, shift and valid pattern
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         rand_in();
         shift_a = ($urandom % 4) == 0;
         shift_b = ($urandom % 4) == 0;
      end
      @(negedge clk);
      in_vld = 1'b0; shift_a = 1'b0; shift_b = 1'b0;
      repeat (5) @(negedge clk);
      done = 1'b1;
      report();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         top_chk++;
         top_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         report();
         $finish;
      end
   end
endmodule